// File: doc/BRIEF.md
# Offset Calibration Run Sequencer

This block decides when a serial audio converter front end runs its offset calibration, and for how long. A run is requested in two ways. The first is the release of the block reset. The second is a switch of the mode select from control mode to data mode. The run does not start until a reference settle timer has expired, and that timer restarts at power up and on every power down. The run then lasts a fixed number of frame sync periods. Frame sync is sampled in the system clock domain, and each rising edge counts as one period.

From the moment a run is requested until it ends, the block holds every outgoing serial data bit at zero. It also raises a converter-invalid flag, and the frame formatter inserts that flag at a fixed slot and bit position of the outgoing frame. The input channel select is captured when counting begins and held for the analog side. Changes to it during the run are ignored. A request that arrives while a run is pending or in progress restarts the run from frame zero, and the invalid flag stays high across the restart. The end of a run is marked by a one-cycle done pulse.

Top module: `calseq_top`

## Requirements
- R1: While rst_n is low, busy_o and adc_invalid_o are 1, done_o is 0, and ser_bit_o is 0 at every position except the status position.
- R2: Frame counting starts only after pwr_down_i has been low for SETTLE_CYCLES clock cycles without a break since reset, or since the last power down. Until then the run stays pending, with busy_o and adc_invalid_o at 1.
- R3: Counting starts on the first clock edge after the settle timer has expired. One cycle after the edge that samples the FRAMES-th frame sync rise (fsync_i high after a low cycle), busy_o and adc_invalid_o fall to 0.
- R4: In idle, a 0-to-1 change of mode_data_i (1 = data mode, 0 = control mode) starts a new pending run. A 1-to-0 change has no effect.
- R5: While busy_o is 1, ser_bit_o is 0 at every non-status position. While idle, ser_bit_o follows ser_bit_i.
- R6: At the status position (slot_idx_i = 6 and bit_idx_i = 7), ser_bit_o equals adc_invalid_o, whatever ser_bit_i is.
- R7: cal_sel_o takes the value of in_sel_i on the edge where counting starts, and holds that value until the next time counting starts.
- R8: A 0-to-1 change of mode_data_i while busy restarts the run from frame zero, with a new settle check. adc_invalid_o stays 1 and no done pulse occurs, even when the change coincides with the final frame sync rise.
- R9: Asserting pwr_down_i during a run returns the run to pending with the frame count cleared and adc_invalid_o held at 1. Counting resumes only after a new settle period.
- R10: done_o is high for exactly one cycle, in the same cycle that busy_o first reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release requests a run |
| pwr_down_i | input | 1 | Power down; clears the settle timer |
| mode_data_i | input | 1 | Mode select, 1 = data mode, 0 = control mode |
| fsync_i | input | 1 | Frame sync, synchronous to clk |
| in_sel_i | input | 1 | Input channel select |
| slot_idx_i | input | SLOT_W | Slot index of the outgoing bit |
| bit_idx_i | input | BIT_W | Bit index within the slot of the outgoing bit |
| ser_bit_i | input | 1 | Outgoing data bit from the frame formatter |
| ser_bit_o | output | 1 | Gated outgoing bit with the status flag inserted |
| adc_invalid_o | output | 1 | Converter-invalid flag |
| busy_o | output | 1 | A run is pending or in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| cal_sel_o | output | 1 | Input select captured at the start of the run |

## Verification
Two events can land on the same clock edge: the final frame sync rise, which would end the run, and a control-to-data mode edge, which restarts it. The bench provokes this by driving frame sync by hand until its own model reaches the last frame. It then raises frame sync and the mode select together. The bench judges the outcome on the next cycle: no done pulse, busy still high, invalid flag still high. A reference model then follows the restarted run through to its single done pulse.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } cal_state_e;

    // Position of the converter-invalid flag inside the outgoing frame
    localparam int STATUS_SLOT = 6;
    localparam int STATUS_BIT  = 7;

endpackage

// File: rtl/calseq_edge.sv
module calseq_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_rise
        assign rise_o[i] = sig_i[i] & ~prev_q[i];
    end

endmodule

// File: rtl/calseq_settle.sv
module calseq_settle #(
    parameter int CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic settled_o
);

    localparam int TW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
    localparam logic [TW-1:0] LIMIT = TW'(CYCLES);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)              cnt_d = '0;
        else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign settled_o = (cnt_q == LIMIT);

    AST_CLR_UNSETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !settled_o); // R9

endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
    import calseq_pkg::*;
#(
    parameter int FRAMES = 194
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_rise_i,
    input  logic md_rise_i,
    input  logic pwr_down_i,
    input  logic settled_i,
    input  logic in_sel_i,
    output logic busy_o,
    output logic invalid_o,
    output logic done_o,
    output logic sel_o
);

    localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

    typedef struct packed {
        cal_state_e    st;
        logic [CW-1:0] cnt;
        logic          done;
        logic          sel;
        logic          inval;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  abort;

    assign abort = pwr_down_i | md_rise_i;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (md_rise_i) begin
                    s_d.st  = ST_WAIT;
                    s_d.cnt = '0;
                end
            end
            ST_WAIT: begin
                s_d.cnt = '0;
                if (!abort && settled_i) begin
                    s_d.st  = ST_RUN;
                    s_d.sel = in_sel_i;
                end
            end
            ST_RUN: begin
                if (abort) begin
                    s_d.st  = ST_WAIT;
                    s_d.cnt = '0;
                end else if (fs_rise_i) begin
                    if (s_q.cnt == LAST) begin
                        s_d.st   = ST_IDLE;
                        s_d.cnt  = '0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        s_d.inval = (s_d.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_WAIT;
            s_q.cnt   <= '0;
            s_q.done  <= 1'b0;
            s_q.sel   <= 1'b0;
            s_q.inval <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.st != ST_IDLE);
    assign invalid_o = s_q.inval;
    assign done_o    = s_q.done;
    assign sel_o     = s_q.sel;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done); // R10

    AST_DONE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.inval); // R3

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST); // R3

    AST_RESTART_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (md_rise_i && s_q.st != ST_IDLE) |=> (s_q.inval && !s_q.done)); // R8

    AST_SEL_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && $past(s_q.st) == ST_RUN) |-> $stable(s_q.sel)); // R7

    AST_RUN_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.st) == ST_WAIT && s_q.st == ST_RUN) |-> $past(settled_i)); // R2

endmodule

// File: rtl/calseq_top.sv
module calseq_top
    import calseq_pkg::*;
#(
    parameter int FRAMES        = 194,
    parameter int SETTLE_CYCLES = 12_500_000,
    parameter int SLOT_W        = 3,
    parameter int BIT_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down_i,
    input  logic              mode_data_i,
    input  logic              fsync_i,
    input  logic              in_sel_i,
    input  logic [SLOT_W-1:0] slot_idx_i,
    input  logic [BIT_W-1:0]  bit_idx_i,
    input  logic              ser_bit_i,
    output logic              ser_bit_o,
    output logic              adc_invalid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cal_sel_o
);

    localparam logic [SLOT_W-1:0] FLAG_SLOT = SLOT_W'(STATUS_SLOT);
    localparam logic [BIT_W-1:0]  FLAG_BIT  = BIT_W'(STATUS_BIT);

    logic [1:0] rise;
    logic       settled;
    logic       at_flag;

    calseq_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({mode_data_i, fsync_i}),
        .rise_o (rise)
    );

    calseq_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (pwr_down_i),
        .settled_o (settled)
    );

    calseq_ctrl #(.FRAMES(FRAMES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_rise_i  (rise[0]),
        .md_rise_i  (rise[1]),
        .pwr_down_i (pwr_down_i),
        .settled_i  (settled),
        .in_sel_i   (in_sel_i),
        .busy_o     (busy_o),
        .invalid_o  (adc_invalid_o),
        .done_o     (done_o),
        .sel_o      (cal_sel_o)
    );

    assign at_flag = (slot_idx_i == FLAG_SLOT) && (bit_idx_i == FLAG_BIT);

    always_comb begin
        if (at_flag)     ser_bit_o = adc_invalid_o;
        else if (busy_o) ser_bit_o = 1'b0;
        else             ser_bit_o = ser_bit_i;
    end

endmodule

// File: tb/calseq_top_test.sv
module calseq_top_test;

    localparam int F = 194;
    localparam int S = 40;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, pwr = 1'b0, mode = 1'b0, fs = 1'b0, sel = 1'b0, sbi = 1'b0;
    logic [2:0] slot = 3'd0, bidx = 3'd0;
    logic       sbo, inval, busy, done, csel;

    int n_chk = 0, n_fail = 0;
    bit auto_fs = 1'b1;
    int ph = 0, per = 6;

    calseq_top #(.FRAMES(F), .SETTLE_CYCLES(S)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr), .mode_data_i(mode),
        .fsync_i(fs), .in_sel_i(sel), .slot_idx_i(slot), .bit_idx_i(bidx),
        .ser_bit_i(sbi), .ser_bit_o(sbo), .adc_invalid_o(inval),
        .busy_o(busy), .done_o(done), .cal_sel_o(csel)
    );

    // reference model: 0 idle, 1 pending, 2 counting
    int m_st, m_cnt, m_sc;
    logic m_sel, m_done, m_fsp, m_mdp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 1; m_cnt = 0; m_sc = 0; m_sel = 0; m_done = 0; m_fsp = 0; m_mdp = 0;
        end else begin
            automatic bit fr = fs && !m_fsp;
            automatic bit mr = mode && !m_mdp;
            automatic bit settled = (m_sc == S);
            m_done = 0;
            case (m_st)
                0: if (mr) begin m_st = 1; m_cnt = 0; end
                1: begin
                    m_cnt = 0;
                    if (!(pwr || mr) && settled) begin m_st = 2; m_sel = sel; end
                end
                default: begin
                    if (pwr || mr) begin m_st = 1; m_cnt = 0; end
                    else if (fr) begin
                        if (m_cnt == F - 1) begin m_st = 0; m_cnt = 0; m_done = 1; end
                        else m_cnt++;
                    end
                end
            endcase
            m_sc = pwr ? 0 : (settled ? S : m_sc + 1);
            m_fsp = fs; m_mdp = mode;
        end
    end

    function automatic logic exp_ser(int st, logic [2:0] sl, logic [2:0] bi, logic d);
        if (sl == 3'd6 && bi == 3'd7) return st != 0;
        if (st != 0) return 1'b0;
        return d;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (auto_fs) begin
            ph = (ph + 1 >= per) ? 0 : ph + 1;
            fs = (ph == 0);
        end
        #1;
        if (rst_n) begin
            chk(m_st == 1 ? "R2 busy" : "R3 busy", busy, m_st != 0);
            chk(m_st == 1 ? "R2 invalid" : "R3 invalid", inval, m_st != 0);
            chk("R10 done", done, m_done);
            chk("R7 cal_sel", csel, m_sel);
            chk((slot == 3'd6 && bidx == 3'd7) ? "R6 status bit" : "R5 data gate",
                sbo, exp_ser(m_st, slot, bidx, sbi));
        end
    endtask

    task automatic run_to_idle(int limit);
        for (int i = 0; i < limit && m_st != 0; i++) tick();
        chk("R3 run finished", busy, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R3 watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: reset state
        slot = 3'd6; bidx = 3'd7; sbi = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy", busy, 1'b1);
        chk("R1 invalid", inval, 1'b1);
        chk("R1 done", done, 1'b0);
        chk("R1 status bit", sbo, 1'b1);
        slot = 3'd2; sbi = 1'b1; #1;
        chk("R1 data gate", sbo, 1'b0);

        // R2/R3: run after reset release, settle then FRAMES periods
        mode = 1'b1; sel = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < S; i++) begin
            tick();
            chk("R2 still pending", busy, 1'b1);
        end
        run_to_idle(F * per + 100);
        chk("R7 captured select", csel, 1'b1);
        tick();
        chk("R5 idle passthrough", sbo, sbi);

        // R4: fall ignored, rise starts
        mode = 1'b0; repeat (4) tick();
        chk("R4 fall ignored", busy, 1'b0);
        sel = 1'b0; mode = 1'b1; tick();
        chk("R4 rise starts", busy, 1'b1);
        repeat (3) tick();
        sel = 1'b1; repeat (5) tick();
        chk("R7 select change ignored", csel, 1'b0);
        run_to_idle(F * per + 100);

        // R8: restart coincides with final frame sync rise
        mode = 1'b0; tick(); mode = 1'b1; tick();
        auto_fs = 1'b0; mode = 1'b0; fs = 1'b0;
        for (int i = 0; i < 4 * F + 200 && !(m_st == 2 && m_cnt == F - 1); i++) begin
            fs = ~fs; tick();
        end
        fs = 1'b0; tick();
        fs = 1'b1; mode = 1'b1; tick();
        chk("R8 no done on coincidence", done, 1'b0);
        chk("R8 still busy", busy, 1'b1);
        chk("R8 flag held", inval, 1'b1);
        auto_fs = 1'b1;
        run_to_idle(F * per + 100);

        // R9: power down during run
        mode = 1'b0; tick(); mode = 1'b1; tick();
        repeat (S + 300) tick();
        pwr = 1'b1; repeat (10) tick();
        chk("R9 flag held in power down", inval, 1'b1);
        pwr = 1'b0;
        for (int i = 0; i < S; i++) begin
            tick();
            chk("R9 waits for settle", busy, 1'b1);
        end
        run_to_idle(F * per + 100);

        // random phase
        for (int c = 0; c < 30000; c++) begin
            if (ph == 0 && $urandom_range(0, 3) == 0) per = $urandom_range(3, 10);
            if ($urandom_range(0, 599) == 0) mode = ~mode;
            if (!pwr && $urandom_range(0, 2999) == 0) pwr = 1'b1;
            else if (pwr && $urandom_range(0, 30) == 0) pwr = 1'b0;
            if ($urandom_range(0, 19) == 0) sel = ~sel;
            sbi = 1'($urandom());
            if ($urandom_range(0, 3) == 0) begin slot = 3'd6; bidx = 3'd7; end
            else begin slot = 3'($urandom()); bidx = 3'($urandom()); end
            tick();
        end
        pwr = 1'b0;
        run_to_idle(F * 12 + 200);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule